// File: doc/BRIEF.md
# Variable-Length Instruction Field Splitter

This block sits between instruction fetch and the rest of a small 32-bit processor. Fetch hands it a six-byte window read at the current program counter, with byte 0 in the lowest eight bits of the window. The block breaks the window into fields:
- the class code and the function code,
- two register identifiers,
- a 32-bit constant.

It also reports the instruction's byte length, the address of the next sequential instruction, a "defined" flag and a three-valued status.

The length comes from byte 0 alone. Instructions take 1, 2, 5 or 6 bytes. Constants are stored least-significant byte first. Register identifier 0xF means "no register". Byte 0x00 decodes as halt, so a fetch from zeroed memory stops the machine. Memory access, address-range checks and execution are handled elsewhere.

The block is combinational by default. Setting `OUT_REG` adds one output register stage.

Top module: `instr_splitter`

## Requirements
- R1: `out_icode` always equals window bits [7:4] and `out_ifun` always equals bits [3:0], whether or not the instruction is defined.
- R2: For a defined instruction, `out_len` is set by class code:
  - 1 for classes 0 (halt), 1 (no-op) and 9 (return);
  - 2 for classes 2 (register copy), 6 (arithmetic), A (push) and B (pop);
  - 5 for classes 7 (jump) and 8 (call);
  - 6 for classes 3 (immediate load), 4 (store) and 5 (load).
- R3: For defined classes 2, 3, 4, 5, 6, A and B, `out_ra` is byte 1 bits [7:4] and `out_rb` is byte 1 bits [3:0]. For every other defined class, both are 0xF.
- R4: `out_valc` takes its bytes as follows, least-significant byte first:
  - bytes 2..5 for classes 3, 4 and 5;
  - bytes 1..4 for classes 7 and 8;
  - zero for every other class.
- R5: Byte 0 equal to 0x00 gives `out_stat` = 2 (halt) with `out_ok` = 1 and length 1. Every other defined instruction gives `out_stat` = 1 (normal).
- R6: A class code above 0xB gives `out_stat` = 4 (invalid) and `out_ok` = 0.
- R7: Within classes 0..B, a function code is legal as follows:
  - 0..3 in class 6;
  - 0..6 in class 7;
  - only 0 in every other class.
  
  Any other function code gives `out_stat` = 4 and `out_ok` = 0.
- R8: For an invalid instruction, `out_len` = 1, `out_ra` = `out_rb` = 0xF and `out_valc` = 0.
- R9: `out_next_pc` equals `fetch_pc + out_len`, modulo 2^32.
- R10: With `OUT_REG` = 1, every output shows the decode of the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage and the checks |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Address of byte 0 of the window |
| fetch_win | input | 48 | Fetched bytes; byte k sits in bits [8k+7:8k] |
| out_icode | output | 4 | Class code |
| out_ifun | output | 4 | Function code |
| out_ra | output | 4 | First register identifier, 0xF if none |
| out_rb | output | 4 | Second register identifier, 0xF if none |
| out_valc | output | 32 | Constant or target address |
| out_len | output | 3 | Instruction length in bytes |
| out_next_pc | output | 32 | fetch_pc plus length |
| out_ok | output | 1 | Instruction is defined |
| out_stat | output | 3 | 1 normal, 2 halt, 4 invalid |

## Verification
The bench sweeps all 256 first-byte values against three tail patterns and three program counters. This exposes the following faults:
- A length table that is off by one class would report a wrong `out_len` and a wrong next address.
- A constant taken from the wrong offset would be reported for jump and call, which have no register byte.
- A function-code limit written with `<` instead of `<=` would reject arithmetic code 3 or jump code 6, and a missing limit would accept them.
- An invalid instruction that leaks byte-1 fields would fail the check on `out_ra`, `out_rb` and `out_valc`.

One program counter sits two bytes below the top of the address space, so a next-address adder that does not wrap would show up. The registered copy is compared one edge later to catch a stage that adds or drops a cycle.

// File: rtl/isplit_pkg.sv
package isplit_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_AOK  = 3'd1,
    ST_HLT  = 3'd2,
    ST_ADR  = 3'd3,
    ST_INS  = 3'd4
  } stat_e;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_AT1  = 2'd1,
    K_AT2  = 2'd2
  } kpos_e;

  localparam logic [3:0] OP_HALT  = 4'h0;
  localparam logic [3:0] OP_NOP   = 4'h1;
  localparam logic [3:0] OP_RRMOV = 4'h2;
  localparam logic [3:0] OP_IRMOV = 4'h3;
  localparam logic [3:0] OP_STORE = 4'h4;
  localparam logic [3:0] OP_LOAD  = 4'h5;
  localparam logic [3:0] OP_ALU   = 4'h6;
  localparam logic [3:0] OP_JMP   = 4'h7;
  localparam logic [3:0] OP_CALL  = 4'h8;
  localparam logic [3:0] OP_RET   = 4'h9;
  localparam logic [3:0] OP_PUSH  = 4'hA;
  localparam logic [3:0] OP_POP   = 4'hB;
  localparam logic [3:0] NO_REG   = 4'hF;

  // Highest legal function code for each class.
  function automatic logic fun_legal(input logic [3:0] op, input logic [3:0] fn);
    case (op)
      OP_ALU:  return fn <= 4'd3;
      OP_JMP:  return fn <= 4'd6;
      default: return fn == 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/isplit_class_decode.sv
module isplit_class_decode
  import isplit_pkg::*;
#(
  parameter int DW = 32,
  localparam int KB = DW / 8,
  localparam int LEN_W = $clog2(KB + 3)
) (
  input  logic [7:0]       head,
  output logic             legal,
  output logic             has_regs,
  output kpos_e            kpos,
  output stat_e            stat,
  output logic [LEN_W-1:0] len
);

  logic [3:0] op;
  logic [3:0] fn;
  logic       known;
  logic       r_raw;
  kpos_e      k_raw;

  // Length: one head byte, an optional register byte, an optional constant.
  function automatic logic [LEN_W-1:0] span(input logic r, input kpos_e k);
    return LEN_W'(1) + LEN_W'(r) + ((k != K_NONE) ? LEN_W'(KB) : '0);
  endfunction

  assign op = head[7:4];
  assign fn = head[3:0];

  always_comb begin
    known = 1'b1;
    r_raw = 1'b0;
    k_raw = K_NONE;
    case (op)
      OP_HALT, OP_NOP, OP_RET: ;
      OP_RRMOV, OP_ALU, OP_PUSH, OP_POP: r_raw = 1'b1;
      OP_IRMOV, OP_STORE, OP_LOAD: begin
        r_raw = 1'b1;
        k_raw = K_AT2;
      end
      OP_JMP, OP_CALL: k_raw = K_AT1;
      default: known = 1'b0;
    endcase
  end

  always_comb begin
    legal = known && fun_legal(op, fn);
    if (legal) begin
      has_regs = r_raw;
      kpos     = k_raw;
      len      = span(r_raw, k_raw);
      stat     = (op == OP_HALT) ? ST_HLT : ST_AOK;
    end else begin
      has_regs = 1'b0;
      kpos     = K_NONE;
      len      = LEN_W'(1);
      stat     = ST_INS;
    end
  end

endmodule

// File: rtl/isplit_field_extract.sv
module isplit_field_extract
  import isplit_pkg::*;
#(
  parameter int DW = 32,
  localparam int TAIL_W = 8 + DW
) (
  input  logic [TAIL_W-1:0] tail,
  input  logic              has_regs,
  input  kpos_e             kpos,
  output logic [3:0]        ra,
  output logic [3:0]        rb,
  output logic [DW-1:0]     konst
);

  // tail[7:0] is byte 1; the window is already little-endian, so a constant
  // is a straight slice starting at its first byte.
  assign ra = has_regs ? tail[7:4] : NO_REG;
  assign rb = has_regs ? tail[3:0] : NO_REG;

  always_comb begin
    case (kpos)
      K_AT1:   konst = tail[DW-1:0];
      K_AT2:   konst = tail[DW+7:8];
      default: konst = '0;
    endcase
  end

endmodule

// File: rtl/instr_splitter.sv
module instr_splitter
  import isplit_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter bit OUT_REG = 1'b0,
  localparam int KB = DW / 8,
  localparam int WIN_W = 8 * (KB + 2),
  localparam int LEN_W = $clog2(KB + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    fetch_pc,
  input  logic [WIN_W-1:0] fetch_win,
  output logic [3:0]       out_icode,
  output logic [3:0]       out_ifun,
  output logic [3:0]       out_ra,
  output logic [3:0]       out_rb,
  output logic [DW-1:0]    out_valc,
  output logic [LEN_W-1:0] out_len,
  output logic [AW-1:0]    out_next_pc,
  output logic             out_ok,
  output logic [2:0]       out_stat
);

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] pc,
                                            input logic [LEN_W-1:0] n);
    return pc + AW'(n);
  endfunction

  // Named decode events, visible to the assertions below.
  logic             c_ok;
  logic             c_has_regs;
  kpos_e            c_kpos;
  stat_e            c_stat;
  logic [LEN_W-1:0] c_len;
  logic [3:0]       c_ra;
  logic [3:0]       c_rb;
  logic [DW-1:0]    c_valc;
  logic [AW-1:0]    c_next;

  isplit_class_decode #(.DW(DW)) u_class (
    .head     (fetch_win[7:0]),
    .legal    (c_ok),
    .has_regs (c_has_regs),
    .kpos     (c_kpos),
    .stat     (c_stat),
    .len      (c_len)
  );

  isplit_field_extract #(.DW(DW)) u_fields (
    .tail     (fetch_win[WIN_W-1:8]),
    .has_regs (c_has_regs),
    .kpos     (c_kpos),
    .ra       (c_ra),
    .rb       (c_rb),
    .konst    (c_valc)
  );

  assign c_next = advance(fetch_pc, c_len);

  generate
    if (OUT_REG) begin : g_reg
      logic armed;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_icode   <= '0;
          out_ifun    <= '0;
          out_ra      <= '0;
          out_rb      <= '0;
          out_valc    <= '0;
          out_len     <= '0;
          out_next_pc <= '0;
          out_ok      <= 1'b0;
          out_stat    <= '0;
          armed       <= 1'b0;
        end else begin
          out_icode   <= fetch_win[7:4];
          out_ifun    <= fetch_win[3:0];
          out_ra      <= c_ra;
          out_rb      <= c_rb;
          out_valc    <= c_valc;
          out_len     <= c_len;
          out_next_pc <= c_next;
          out_ok      <= c_ok;
          out_stat    <= 3'(c_stat);
          armed       <= 1'b1;
        end
      end

      // R10: the stage is exactly one edge deep.
      a_r10_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (out_len == $past(c_len) && out_ok == $past(c_ok)
                   && out_valc == $past(c_valc) && out_next_pc == $past(c_next)));
    end else begin : g_comb
      assign out_icode   = fetch_win[7:4];
      assign out_ifun    = fetch_win[3:0];
      assign out_ra      = c_ra;
      assign out_rb      = c_rb;
      assign out_valc    = c_valc;
      assign out_len     = c_len;
      assign out_next_pc = c_next;
      assign out_ok      = c_ok;
      assign out_stat    = 3'(c_stat);
    end
  endgenerate

  a_r2_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    c_ok |-> (c_len == LEN_W'(1) || c_len == LEN_W'(2)
              || c_len == LEN_W'(KB + 1) || c_len == LEN_W'(KB + 2)));

  a_r3_no_reg_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ok && !c_has_regs) |-> (c_ra == NO_REG && c_rb == NO_REG));

  a_r5_zero_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_win[7:0] == 8'h00) |-> (c_stat == ST_HLT && c_ok && c_len == LEN_W'(1)));

  a_r8_bad_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (c_stat == ST_INS) |-> (!c_ok && c_len == LEN_W'(1) && c_ra == NO_REG
                            && c_rb == NO_REG && c_valc == '0));

endmodule

// File: tb/instr_splitter_bench.sv
module instr_splitter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc = '0;
  logic [47:0] win = '0;

  logic [3:0]  d_icode, d_ifun, d_ra, d_rb, q_icode, q_ifun, q_ra, q_rb;
  logic [31:0] d_valc, d_npc, q_valc, q_npc;
  logic [2:0]  d_len, d_stat, q_len, q_stat;
  logic        d_ok, q_ok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  instr_splitter u_instr_splitter (
    .clk(clk), .rst_n(rst_n), .fetch_pc(pc), .fetch_win(win),
    .out_icode(d_icode), .out_ifun(d_ifun), .out_ra(d_ra), .out_rb(d_rb),
    .out_valc(d_valc), .out_len(d_len), .out_next_pc(d_npc),
    .out_ok(d_ok), .out_stat(d_stat)
  );

  instr_splitter #(.OUT_REG(1'b1)) u_instr_splitter_q (
    .clk(clk), .rst_n(rst_n), .fetch_pc(pc), .fetch_win(win),
    .out_icode(q_icode), .out_ifun(q_ifun), .out_ra(q_ra), .out_rb(q_rb),
    .out_valc(q_valc), .out_len(q_len), .out_next_pc(q_npc),
    .out_ok(q_ok), .out_stat(q_stat)
  );

  // Expected values, built from class masks rather than a case table.
  logic [3:0]  e_ra, e_rb;
  logic [31:0] e_valc, e_npc;
  logic [2:0]  e_len, e_stat;
  logic        e_ok;

  task automatic model(input logic [47:0] w, input logic [31:0] p);
    logic [3:0] op, fn, fmax;
    logic r, k1, k2;
    op = w[7:4];
    fn = w[3:0];
    r  = 16'h0C7C >> op;
    k1 = 16'h0180 >> op;
    k2 = 16'h0038 >> op;
    fmax = (op == 4'h6) ? 4'd3 : (op == 4'h7) ? 4'd6 : 4'd0;
    e_ok   = (op <= 4'hB) && (fn <= fmax);
    e_len  = e_ok ? 3'd1 + {2'b0, r} + ((k1 | k2) ? 3'd4 : 3'd0) : 3'd1;
    e_ra   = (e_ok && r) ? w[15:12] : 4'hF;
    e_rb   = (e_ok && r) ? w[11:8]  : 4'hF;
    e_valc = !e_ok ? 32'h0 : k2 ? w[47:16] : k1 ? w[39:8] : 32'h0;
    e_stat = !e_ok ? 3'd4 : (w[7:0] == 8'h00) ? 3'd2 : 3'd1;
    e_npc  = p + {29'b0, e_len};
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h (byte0 %02h)", req, got, exp, win[7:0]);
    end
  endtask

  task automatic check_comb();
    string stag;
    stag = (win[7:4] > 4'hB) ? "R6" : (win[7:0] == 8'h00) ? "R5" : "R7";
    chk("R1 icode", {28'b0, d_icode}, {28'b0, win[7:4]});
    chk("R1 ifun", {28'b0, d_ifun}, {28'b0, win[3:0]});
    chk(e_ok ? "R2 len" : "R8 len", {29'b0, d_len}, {29'b0, e_len});
    chk(e_ok ? "R3 regs" : "R8 regs", {24'b0, d_ra, d_rb}, {24'b0, e_ra, e_rb});
    chk(e_ok ? "R4 valc" : "R8 valc", d_valc, e_valc);
    chk(stag, {28'b0, d_ok, d_stat}, {28'b0, e_ok, e_stat});
    chk("R9 next pc", d_npc, e_npc);
  endtask

  task automatic check_reg();
    chk("R10 fields", {q_icode, q_ifun, q_ra, q_rb, 4'b0, q_ok, q_stat, 13'b0, q_len},
        {win[7:4], win[3:0], e_ra, e_rb, 4'b0, e_ok, e_stat, 13'b0, e_len});
    chk("R10 valc", q_valc, e_valc);
    chk("R10 next pc", q_npc, e_npc);
  endtask

  initial begin
    logic [39:0] tails [3];
    logic [31:0] pcs [3];
    // Pattern 0: byte 1 = 0x82, constant 0x0000abcd.
    tails[0] = 40'h00_00_ab_cd_82;
    tails[1] = 40'h13_57_9b_df_3c;
    tails[2] = 40'hfe_dc_ba_98_e1;
    pcs[0] = 32'h0000_0100;
    pcs[1] = 32'hFFFF_FFFE;
    pcs[2] = 32'h1234_5670;

    #2;
    // R10 reset state: registered outputs all zero while in reset.
    chk("R10 reset", {q_icode, q_ifun, q_ra, q_rb, q_ok, q_stat, q_len, 9'b0},
        32'h0);
    chk("R10 reset valc", q_valc | q_npc, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int p = 0; p < 3; p++) begin
      for (int b = 0; b < 256; b++) begin
        @(negedge clk);
        win = {tails[p], 8'(b)};
        pc  = pcs[p];
        model(win, pc);
        #1 check_comb();
        @(posedge clk);
        #1 check_reg();
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule